// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block places a small word-addressed memory behind several requester ports and executes indivisible operations on it: plain read, plain write, exchange, compare-and-swap, fetch-and-add, load-linked and store-conditional. Every operation reads the addressed word and, where it applies, writes it back within one granted cycle. No other requester can observe or change the word between the read and the write, so software can build locks, counters and barriers on it.

A round-robin arbiter picks at most one pending request per cycle. The chosen requester sees its grant bit high, and one cycle later it sees a response pulse carrying a data word and a success flag. Each requester owns one load-linked reservation, made of a valid bit and an address. A successful write to the reserved address by any other requester breaks that reservation, so a later store-conditional fails and reports it through the success flag.

Per-requester fields are packed into flat vectors. Requester i uses slice `[i*W +: W]` of each vector, where W is the width of the field.

Top module: `amo_unit`

## Requirements
- R1: After reset, every memory word reads zero, no grant or response is active, and no requester holds a reservation.
- R2: Opcode 1 (write) stores operand A and returns the old value. Opcode 0 (read) returns the stored value and leaves it unchanged. Both report ok=1.
- R3: Opcode 2 (exchange) returns the old word and stores operand A in the same slot. It reports ok=1.
- R4: Opcode 3 (compare-and-swap) stores operand B only when the word equals operand A, and then reports ok=1. Otherwise the word is unchanged and ok=0. The old word is returned in both cases.
- R5: Opcode 4 (fetch-and-add) stores the word plus operand A, modulo 2^32, and returns that sum. It reports ok=1.
- R6: Opcode 5 (load-linked) returns the word and reserves its address for the issuer. A following opcode 6 (store-conditional) to that address, with the reservation intact, stores operand A and reports ok=1.
- R7: A store-conditional fails when the issuer holds no reservation, or holds one for a different address. On failure it reports ok=0 and performs no write.
- R8: A store-conditional clears the issuer's own reservation whether it succeeds or fails, so a second store-conditional fails.
- R9: A successful write by one requester to an address clears every other requester's reservation on that address. Reads and load-linked operations by others leave the reservation intact.
- R10: At most one grant is active per cycle, and only to a requester with a pending request. After granting requester i, the arbiter searches from i+1 upward, wrapping around.
- R11: The response for a grant appears on the granted requester's rsp_valid bit, data and ok in the cycle after the grant, and only there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | N_REQ | Request pending, one bit per requester, held until granted |
| req_op_i | input | 3*N_REQ | Opcode per requester |
| req_addr_i | input | AW*N_REQ | Word address per requester |
| req_opa_i | input | DW*N_REQ | Operand A per requester |
| req_opb_i | input | DW*N_REQ | Operand B per requester (compare-and-swap new value) |
| req_gnt_o | output | N_REQ | Request accepted at the coming clock edge |
| rsp_valid_o | output | N_REQ | One-cycle response pulse |
| rsp_data_o | output | DW*N_REQ | Returned value |
| rsp_ok_o | output | N_REQ | Success flag |

## Verification
The hardest condition to reach is a reservation that has been broken by a different requester's write between the load-linked and the store-conditional. From the ports this needs three ordered operations from two requesters. The stimulus issues them one after another and then reads the word back through a third requester, which confirms that the failed store left memory untouched. A counterpart sequence writes a different address in between and expects success. The rotation order of the arbiter is reached by first steering its pointer with a single-requester operation, then raising all four requests together and recording the grant order.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_XCHG  = 3'd2,
    OP_CAS   = 3'd3,
    OP_FADD  = 3'd4,
    OP_LL    = 3'd5,
    OP_SC    = 3'd6
  } amo_op_e;

  localparam int OP_W = 3;
endpackage

// File: rtl/amo_rr_arb.sv
module amo_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          fire_o
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    gnt_o  = '0;
    idx_o  = '0;
    fire_o = 1'b0;
    for (int k = 0; k < N; k++) begin
      int c;
      c = (int'(ptr_q) + k) % N;
      if (!fire_o && req_i[c]) begin
        fire_o   = 1'b1;
        idx_o    = IW'(c);
        gnt_o[c] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (fire_o) ptr_q <= (int'(idx_o) == N-1) ? '0 : idx_o + 1'b1;
  end

  assert_one_grant_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  assert_grant_needs_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/amo_mem.sv
module amo_mem #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i
);
  logic [DW-1:0] mem_q [DEPTH];

  assign rdata_o = mem_q[raddr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
  parameter int N  = 4,
  parameter int AW = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_i,
  input  logic [IW-1:0]   idx_i,
  input  amo_pkg::amo_op_e op_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            we_i,
  output logic            hit_o
);
  import amo_pkg::*;

  logic [N-1:0]  vld_q;
  logic [AW-1:0] adr_q [N];

  assign hit_o = vld_q[idx_i] && (adr_q[idx_i] == addr_i);

  for (genvar j = 0; j < N; j++) begin : g_slot
    logic own;
    assign own = fire_i && (int'(idx_i) == j);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[j] <= 1'b0;
        adr_q[j] <= '0;
      end else if (own && op_i == OP_LL) begin
        vld_q[j] <= 1'b1;
        adr_q[j] <= addr_i;
      end else if (own && op_i == OP_SC) begin
        vld_q[j] <= 1'b0;
      end else if (fire_i && we_i && !own && adr_q[j] == addr_i) begin
        vld_q[j] <= 1'b0;
      end
    end

    assert_foreign_write_breaks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire_i && we_i && !own && vld_q[j] && adr_q[j] == addr_i) |=> !vld_q[j]);
    assert_sc_drops_own_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (own && op_i == OP_SC) |=> !vld_q[j]);
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu #(
  parameter int DW = 32
) (
  input  amo_pkg::amo_op_e op_i,
  input  logic [DW-1:0]    old_i,
  input  logic [DW-1:0]    opa_i,
  input  logic [DW-1:0]    opb_i,
  input  logic             resv_hit_i,
  output logic             we_o,
  output logic [DW-1:0]    wdata_o,
  output logic [DW-1:0]    result_o,
  output logic             ok_o
);
  import amo_pkg::*;

  logic [DW-1:0] sum;
  assign sum = old_i + opa_i;

  always_comb begin
    we_o     = 1'b0;
    wdata_o  = opa_i;
    result_o = old_i;
    ok_o     = 1'b1;
    unique case (op_i)
      OP_WRITE, OP_XCHG: we_o = 1'b1;
      OP_CAS: begin
        ok_o    = (old_i == opa_i);
        we_o    = ok_o;
        wdata_o = opb_i;
      end
      OP_FADD: begin
        we_o     = 1'b1;
        wdata_o  = sum;
        result_o = sum;
      end
      OP_SC: begin
        ok_o = resv_hit_i;
        we_o = resv_hit_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/amo_unit.sv
module amo_unit #(
  parameter int N_REQ   = 4,
  parameter int N_WORDS = 16,
  parameter int DW      = 32,
  localparam int AW     = $clog2(N_WORDS),
  localparam int OW     = amo_pkg::OP_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_REQ-1:0]    req_valid_i,
  input  logic [N_REQ*OW-1:0] req_op_i,
  input  logic [N_REQ*AW-1:0] req_addr_i,
  input  logic [N_REQ*DW-1:0] req_opa_i,
  input  logic [N_REQ*DW-1:0] req_opb_i,
  output logic [N_REQ-1:0]    req_gnt_o,
  output logic [N_REQ-1:0]    rsp_valid_o,
  output logic [N_REQ*DW-1:0] rsp_data_o,
  output logic [N_REQ-1:0]    rsp_ok_o
);
  import amo_pkg::*;

  localparam int IW = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  logic [IW-1:0] idx;
  logic          fire;
  amo_op_e       sel_op;
  logic [AW-1:0] sel_addr;
  logic [DW-1:0] sel_a, sel_b, rd_data, wr_data, result;
  logic          we, ok, resv_hit, mem_we;

  amo_rr_arb #(.N(N_REQ)) u_arb (
    .clk_i, .rst_ni, .req_i(req_valid_i), .gnt_o(req_gnt_o), .idx_o(idx), .fire_o(fire)
  );

  assign sel_op   = amo_op_e'(req_op_i[idx*OW +: OW]);
  assign sel_addr = req_addr_i[idx*AW +: AW];
  assign sel_a    = req_opa_i[idx*DW +: DW];
  assign sel_b    = req_opb_i[idx*DW +: DW];

  amo_resv #(.N(N_REQ), .AW(AW)) u_resv (
    .clk_i, .rst_ni, .fire_i(fire), .idx_i(idx), .op_i(sel_op),
    .addr_i(sel_addr), .we_i(mem_we), .hit_o(resv_hit)
  );

  amo_alu #(.DW(DW)) u_alu (
    .op_i(sel_op), .old_i(rd_data), .opa_i(sel_a), .opb_i(sel_b),
    .resv_hit_i(resv_hit), .we_o(we), .wdata_o(wr_data), .result_o(result), .ok_o(ok)
  );

  assign mem_we = fire && we;

  amo_mem #(.DW(DW), .DEPTH(N_WORDS)) u_mem (
    .clk_i, .rst_ni, .raddr_i(sel_addr), .rdata_o(rd_data),
    .we_i(mem_we), .waddr_i(sel_addr), .wdata_i(wr_data)
  );

  for (genvar i = 0; i < N_REQ; i++) begin : g_rsp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rsp_valid_o[i]           <= 1'b0;
        rsp_ok_o[i]              <= 1'b0;
        rsp_data_o[i*DW +: DW]   <= '0;
      end else begin
        rsp_valid_o[i] <= req_gnt_o[i];
        if (req_gnt_o[i]) begin
          rsp_ok_o[i]            <= ok;
          rsp_data_o[i*DW +: DW] <= result;
        end
      end
    end

    assert_rsp_follows_grant_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_gnt_o[i] |=> rsp_valid_o[i]);
  end

  assert_cas_miss_nowrite_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && sel_op == OP_CAS && rd_data != sel_a) |-> !mem_we);
  assert_fadd_writes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && sel_op == OP_FADD) |-> mem_we);
  assert_sc_nohit_nowrite_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && sel_op == OP_SC && !resv_hit) |-> !mem_we);
endmodule

// File: tb/sim_amo_unit.sv
module sim_amo_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam logic [2:0] C_RD = 3'd0, C_WR = 3'd1, C_XC = 3'd2, C_CAS = 3'd3,
                         C_FA = 3'd4, C_LL = 3'd5, C_SC = 3'd6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NR-1:0]    v = '0;
  logic [NR*3-1:0]  ops = '0;
  logic [NR*AW-1:0] adr = '0;
  logic [NR*DW-1:0] opa = '0, opb = '0;
  logic [NR-1:0]    gnt, rvld, rok;
  logic [NR*DW-1:0] rdat;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  amo_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v), .req_op_i(ops), .req_addr_i(adr),
    .req_opa_i(opa), .req_opb_i(opb), .req_gnt_o(gnt), .rsp_valid_o(rvld),
    .rsp_data_o(rdat), .rsp_ok_o(rok)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic do_op(input int i, input logic [2:0] op, input logic [3:0] a,
                       input logic [31:0] x, input logic [31:0] y,
                       output logic [31:0] rd, output logic ok);
    @(negedge clk);
    v[i] = 1'b1; ops[i*3 +: 3] = op; adr[i*AW +: AW] = a;
    opa[i*DW +: DW] = x; opb[i*DW +: DW] = y;
    #1;
    while (!gnt[i]) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    v[i] = 1'b0;
    chk("R11 rsp_valid", {28'd0, rvld}, 32'(1 << i));
    rd = rdat[i*DW +: DW];
    ok = rok[i];
  endtask

  task automatic t_reset();
    logic [31:0] d; logic ok;
    chk("R1 gnt idle", {28'd0, gnt}, 0);
    chk("R1 rsp idle", {28'd0, rvld}, 0);
    do_op(0, C_RD, 4'd0, 0, 0, d, ok);  chk("R1 word0", d, 0);
    do_op(1, C_RD, 4'd15, 0, 0, d, ok); chk("R1 word15", d, 0);
    do_op(2, C_SC, 4'd0, 32'h55, 0, d, ok); chk("R1 no reservation", {31'd0, ok}, 0);
    do_op(3, C_RD, 4'd0, 0, 0, d, ok);  chk("R1 sc left word", d, 0);
  endtask

  task automatic t_rdwr();
    logic [31:0] d; logic ok;
    do_op(0, C_WR, 4'd2, 32'hCAFE_0001, 0, d, ok); chk("R2 write old", d, 0);
    chk("R2 write ok", {31'd0, ok}, 1);
    do_op(1, C_RD, 4'd2, 0, 0, d, ok); chk("R2 read", d, 32'hCAFE_0001);
    do_op(2, C_RD, 4'd2, 0, 0, d, ok); chk("R2 read unchanged", d, 32'hCAFE_0001);
  endtask

  task automatic t_xchg();
    logic [31:0] d; logic ok;
    do_op(1, C_XC, 4'd2, 32'h1111_2222, 0, d, ok); chk("R3 xchg old", d, 32'hCAFE_0001);
    do_op(3, C_RD, 4'd2, 0, 0, d, ok); chk("R3 xchg stored", d, 32'h1111_2222);
  endtask

  task automatic t_cas();
    logic [31:0] d; logic ok;
    do_op(0, C_CAS, 4'd2, 32'h1234, 32'h9999, d, ok);
    chk("R4 miss ok", {31'd0, ok}, 0); chk("R4 miss old", d, 32'h1111_2222);
    do_op(1, C_RD, 4'd2, 0, 0, d, ok); chk("R4 miss unchanged", d, 32'h1111_2222);
    do_op(2, C_CAS, 4'd2, 32'h1111_2222, 32'h9999, d, ok);
    chk("R4 hit ok", {31'd0, ok}, 1); chk("R4 hit old", d, 32'h1111_2222);
    do_op(3, C_RD, 4'd2, 0, 0, d, ok); chk("R4 hit stored", d, 32'h9999);
  endtask

  task automatic t_fadd();
    logic [31:0] d; logic ok;
    do_op(0, C_WR, 4'd9, 32'hFFFF_FFFF, 0, d, ok);
    do_op(1, C_FA, 4'd9, 32'd2, 0, d, ok); chk("R5 wrap sum", d, 32'd1);
    do_op(2, C_FA, 4'd9, 32'd10, 0, d, ok); chk("R5 sum", d, 32'd11);
    do_op(3, C_RD, 4'd9, 0, 0, d, ok); chk("R5 stored", d, 32'd11);
  endtask

  task automatic t_llsc();
    logic [31:0] d; logic ok;
    do_op(0, C_WR, 4'd5, 32'd7, 0, d, ok);
    do_op(0, C_LL, 4'd5, 0, 0, d, ok); chk("R6 ll value", d, 32'd7);
    do_op(1, C_LL, 4'd5, 0, 0, d, ok);
    do_op(2, C_RD, 4'd5, 0, 0, d, ok);
    do_op(0, C_SC, 4'd5, 32'd8, 0, d, ok); chk("R6 sc ok", {31'd0, ok}, 1);
    do_op(3, C_RD, 4'd5, 0, 0, d, ok); chk("R6 sc stored", d, 32'd8);
    do_op(0, C_SC, 4'd5, 32'd50, 0, d, ok); chk("R8 second sc fails", {31'd0, ok}, 0);
    do_op(3, C_RD, 4'd5, 0, 0, d, ok); chk("R8 second sc no write", d, 32'd8);
    // requester 1's reservation was broken by requester 0's store
    do_op(1, C_SC, 4'd5, 32'd60, 0, d, ok); chk("R9 broken by sc", {31'd0, ok}, 0);
    do_op(2, C_LL, 4'd3, 0, 0, d, ok);
    do_op(2, C_SC, 4'd4, 32'd70, 0, d, ok); chk("R7 wrong addr", {31'd0, ok}, 0);
    do_op(3, C_RD, 4'd4, 0, 0, d, ok); chk("R7 wrong addr no write", d, 0);
    do_op(2, C_SC, 4'd3, 32'd70, 0, d, ok); chk("R8 cleared by failed sc", {31'd0, ok}, 0);
  endtask

  task automatic t_break();
    logic [31:0] d; logic ok;
    do_op(0, C_LL, 4'd6, 0, 0, d, ok);
    do_op(1, C_WR, 4'd6, 32'hAB, 0, d, ok);
    do_op(0, C_SC, 4'd6, 32'hCD, 0, d, ok); chk("R9 broken sc fails", {31'd0, ok}, 0);
    do_op(2, C_RD, 4'd6, 0, 0, d, ok); chk("R9 memory kept", d, 32'hAB);
    do_op(0, C_LL, 4'd6, 0, 0, d, ok);
    do_op(1, C_FA, 4'd7, 32'd1, 0, d, ok);
    do_op(0, C_SC, 4'd6, 32'hCD, 0, d, ok); chk("R9 other addr keeps", {31'd0, ok}, 1);
  endtask

  task automatic t_rr(input int last, input string tag);
    logic [31:0] d; logic ok;
    do_op(last, C_RD, 4'd0, 0, 0, d, ok);
    @(negedge clk);
    for (int i = 0; i < NR; i++) begin
      v[i] = 1'b1; ops[i*3 +: 3] = C_RD; adr[i*AW +: AW] = 4'd0;
    end
    #1;
    for (int k = 0; k < NR; k++) begin
      int g, e;
      g = -1;
      e = (last + 1 + k) % NR;
      for (int i = 0; i < NR; i++) if (gnt[i]) g = i;
      chk({"R10 one grant ", tag}, $countones(gnt), 1);
      chk({"R10 order ", tag}, g, e);
      @(posedge clk);
      @(negedge clk);
      chk({"R11 rsp at grantee ", tag}, {28'd0, rvld}, 32'(1 << e));
      v[e] = 1'b0;
      #1;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rdwr();
    t_xchg();
    t_cas();
    t_fadd();
    t_llsc();
    t_break();
    t_rr(3, "from0");
    t_rr(1, "from2");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule